// File: doc/BRIEF.md
# Write-Through Flush Completion Tracker

This block sits beside a write-through L1 data cache and tells the core when a release flush has finished. The cache controller pulses an input each time it sends a write-through to L2 and another each time L2 acknowledges one. The tracker keeps an outstanding write-through count from these pulses. When the core asks for a flush, the tracker enters a flushing phase and keeps a second count, of flush completions, that the cache controller advances with a per-line visit pulse. A flush-done pulse goes to the core only once the completions outnumber the write-throughs still in flight. An acknowledgement seen during the flush consumes one completion.

The cache controller normally pulses the visit input together with each acknowledgement that arrives during a flush, and also once for the flush request itself. The in-flush flag drops after a visit leaves both counts at zero. Both counts are 8 bits wide and saturate. Any attempt to step past either end raises a one-cycle error pulse.

Top module: `wtft_tracker`

## Requirements
- R1: A cycle with `wt_issue_i` high and `wb_ack_i` low raises the outstanding write-through count by one.
- R2: A cycle with `flush_req_i` high and `flush_visit_i` low makes `in_flush_o` read 1 from the next cycle.
- R3: A cycle with `wb_ack_i` high and `wt_issue_i` low lowers the outstanding count by one. If the block is flushing in that cycle (`in_flush_o` high or `flush_req_i` high), the same cycle also lowers the completion count by one.
- R4: A `flush_visit_i` pulse while flushing raises the completion count by one, after that cycle's acknowledgement has been taken off. If the result is greater than the outstanding count as updated in that cycle, `flush_done_o` is high for exactly the next cycle and the completion count is taken back down by one. A visit while not flushing has no effect.
- R5: `in_flush_o` returns to 0 after a cycle that carries a visit while flushing and leaves both counts at zero. Otherwise it stays at 1.
- R6: An acknowledgement with the outstanding count at 0 and no issue in the same cycle leaves the count at 0 and makes `err_o` high for the next cycle.
- R7: An issue with the outstanding count at 255 and no acknowledgement leaves the count at 255 and pulses `err_o`. An acknowledgement during a flush that would take the completion count below 0, with no visit in the same cycle, leaves that count at 0 and pulses `err_o`.
- R8: An issue and an acknowledgement in the same cycle leave the outstanding count unchanged and raise no error, even at 0 or 255.
- R9: While reset is active and after it is released, all outputs are 0 and both counts are 0.
- R10: All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wt_issue_i | input | 1 | One write-through sent to L2 this cycle |
| wb_ack_i | input | 1 | One write-through acknowledged by L2 this cycle |
| flush_req_i | input | 1 | Core requests a release flush |
| flush_visit_i | input | 1 | Cache controller finished one flush-completion step |
| flush_done_o | output | 1 | One-cycle pulse: the flush has completed |
| in_flush_o | output | 1 | Flushing phase is active |
| err_o | output | 1 | One-cycle pulse on counter overflow or underflow |

## Verification
The bench tries the block with several input patterns.

- **Flush with write-throughs in flight, then paired ack-and-visit pulses.** This shows that done waits for the final acknowledgement rather than the first.
- **Flush with nothing outstanding.** This separates the immediate-completion path and the flag clearing in one visit.
- **Visits outside a flush.** These must change nothing.
- **Lone acknowledgements during a flush.** These expose the consumption of completions and its underflow.
- **Simultaneous issue and acknowledgement at both count extremes, and a run of 257 issues.** These tell the hold rule apart from the saturation and error rules.

A behavioural model is stepped with the same inputs and compared on every cycle.

// File: rtl/wtft_pkg.sv
`timescale 1ns/1ps
package wtft_pkg;

  // Input events sampled in one cycle
  typedef struct packed {
    logic issue;
    logic ack;
    logic flush;
    logic visit;
  } wtft_ev_t;

endpackage

// File: rtl/wtft_rst_sync.sv
`timescale 1ns/1ps
module wtft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wtft_wt_counter.sv
`timescale 1ns/1ps
module wtft_wt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic cnt_en;

  always_comb begin
    cnt_nxt = cnt_q;
    ovf     = 1'b0;
    unf     = 1'b0;
    unique case ({inc, dec})
      2'b10: begin
        if (cnt_q == CNT_MAX) ovf     = 1'b1;
        else                  cnt_nxt = cnt_q + 1'b1;
      end
      2'b01: begin
        if (cnt_q == '0) unf     = 1'b1;
        else             cnt_nxt = cnt_q - 1'b1;
      end
      default: ;
    endcase
  end

  assign cnt_en = inc ^ dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/wtft_flush_ctrl.sv
`timescale 1ns/1ps
module wtft_flush_ctrl
  import wtft_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wtft_ev_t         ev,
  input  logic [CNT_W-1:0] wt_nxt,
  output logic [CNT_W-1:0] fl_q,
  output logic             in_flush_q,
  output logic             done_q,
  output logic             fl_unf
);
  localparam int EXT_W = CNT_W + 1;

  logic             active;
  logic             dec_hit;
  logic             vis_hit;
  logic [EXT_W-1:0] fl_sum;
  logic [CNT_W-1:0] fl_nxt;
  logic             done_nxt;
  logic             in_flush_nxt;
  logic             fl_en;

  always_comb begin
    active   = in_flush_q | ev.flush;
    dec_hit  = ev.ack & active;
    vis_hit  = ev.visit & active;
    fl_unf   = dec_hit & ~vis_hit & (fl_q == '0);
    fl_sum   = {1'b0, fl_q} + EXT_W'(vis_hit) - EXT_W'(dec_hit);
    done_nxt = vis_hit & ~fl_unf & (fl_sum > {1'b0, wt_nxt});
    if (fl_unf)        fl_nxt = '0;
    else if (done_nxt) fl_nxt = CNT_W'(fl_sum - 1'b1);
    else               fl_nxt = CNT_W'(fl_sum);
    in_flush_nxt = active & ~(vis_hit & (wt_nxt == '0) & (fl_nxt == '0));
    fl_en        = dec_hit | vis_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_en) fl_q <= fl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flush_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      in_flush_q <= in_flush_nxt;
      done_q     <= done_nxt;
    end
  end
endmodule

// File: rtl/wtft_tracker.sv
`timescale 1ns/1ps
module wtft_tracker
  import wtft_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic wt_issue_i,
  input  logic wb_ack_i,
  input  logic flush_req_i,
  input  logic flush_visit_i,
  output logic flush_done_o,
  output logic in_flush_o,
  output logic err_o
);
  logic             rst_sync_n;
  wtft_ev_t         ev;
  logic [CNT_W-1:0] wt_cnt_q;
  logic [CNT_W-1:0] wt_cnt_nxt;
  logic [CNT_W-1:0] fl_cnt_q;
  logic             wt_ovf;
  logic             wt_unf;
  logic             fl_unf;
  logic             err_nxt;
  logic             err_q;

  wtft_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_sync_n)
  );

  assign ev = '{issue: wt_issue_i, ack: wb_ack_i, flush: flush_req_i, visit: flush_visit_i};

  wtft_wt_counter #(.CNT_W(CNT_W)) u_wt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc     (ev.issue),
    .dec     (ev.ack),
    .cnt_q   (wt_cnt_q),
    .cnt_nxt (wt_cnt_nxt),
    .ovf     (wt_ovf),
    .unf     (wt_unf)
  );

  wtft_flush_ctrl #(.CNT_W(CNT_W)) u_fl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev         (ev),
    .wt_nxt     (wt_cnt_nxt),
    .fl_q       (fl_cnt_q),
    .in_flush_q (in_flush_o),
    .done_q     (flush_done_o),
    .fl_unf     (fl_unf)
  );

  assign err_nxt = wt_ovf | wt_unf | fl_unf;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_nxt;
  end

  assign err_o = err_q;
endmodule

// File: rtl/wtft_tracker_chk.sv
`timescale 1ns/1ps
module wtft_tracker_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wt_issue_i,
  input logic             wb_ack_i,
  input logic             flush_req_i,
  input logic             flush_visit_i,
  input logic             flush_done_o,
  input logic             in_flush_o,
  input logic             err_o,
  input logic [CNT_W-1:0] wt_cnt,
  input logic [CNT_W-1:0] fl_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_ISSUE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_issue_i && !wb_ack_i && wt_cnt != CNT_MAX) |=> wt_cnt == CNT_W'($past(wt_cnt) + 1'b1)); // R1

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_i && !flush_visit_i) |=> in_flush_o); // R2

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done_o |-> ($past(flush_visit_i) && ($past(in_flush_o) || $past(flush_req_i)))); // R4

  AST_IDLE_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_visit_i && !in_flush_o && !flush_req_i) |=> !flush_done_o); // R4

  AST_CLEAR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_flush_o) |-> (wt_cnt == '0 && fl_cnt == '0)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack_i && !wt_issue_i && wt_cnt == '0) |=> (err_o && wt_cnt == '0)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_issue_i && !wb_ack_i && wt_cnt == CNT_MAX) |=> (err_o && wt_cnt == CNT_MAX)); // R7

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_issue_i && wb_ack_i) |=> $stable(wt_cnt)); // R8
endmodule

bind wtft_tracker wtft_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .wt_issue_i    (wt_issue_i),
  .wb_ack_i      (wb_ack_i),
  .flush_req_i   (flush_req_i),
  .flush_visit_i (flush_visit_i),
  .flush_done_o  (flush_done_o),
  .in_flush_o    (in_flush_o),
  .err_o         (err_o),
  .wt_cnt        (wt_cnt_q),
  .fl_cnt        (fl_cnt_q)
);

// File: tb/wtft_tracker_tb_top.sv
`timescale 1ns/1ps
module wtft_tracker_tb_top;
  logic clk;
  logic arst_n;
  logic wt_issue_i, wb_ack_i, flush_req_i, flush_visit_i;
  logic flush_done_o, in_flush_o, err_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;

  // behavioural model state
  int  m_wt = 0;
  int  m_fl = 0;
  bit  m_inf = 0;
  bit  m_done = 0;
  bit  m_err = 0;
  int  done_seen = 0;

  wtft_tracker dut_i (
    .clk           (clk),
    .arst_n        (arst_n),
    .wt_issue_i    (wt_issue_i),
    .wb_ack_i      (wb_ack_i),
    .flush_req_i   (flush_req_i),
    .flush_visit_i (flush_visit_i),
    .flush_done_o  (flush_done_o),
    .in_flush_o    (in_flush_o),
    .err_o         (err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit iss, input bit ack, input bit flr, input bit vis);
    bit f;
    int t;
    f = m_inf || flr;
    m_done = 0;
    m_err = 0;
    if (iss && !ack) begin
      if (m_wt == 255) m_err = 1; else m_wt++;
    end else if (ack && !iss) begin
      if (m_wt == 0) m_err = 1; else m_wt--;
    end
    t = m_fl;
    if (ack && f) t--;
    if (vis && f) begin
      t++;
      if (t > m_wt) begin m_done = 1; t--; end
    end
    if (t < 0) begin m_err = 1; t = 0; end
    m_fl = t;
    m_inf = f && !(vis && m_wt == 0 && m_fl == 0);
  endtask

  // drive one cycle, update model at the edge, compare at the falling edge (R10)
  task automatic step(input bit iss, input bit ack, input bit flr, input bit vis, input string tag);
    wt_issue_i = iss; wb_ack_i = ack; flush_req_i = flr; flush_visit_i = vis;
    @(posedge clk);
    model_step(iss, ack, flr, vis);
    @(negedge clk);
    if (m_done) done_seen++;
    check(flush_done_o, m_done, tag, "flush_done_o");
    check(in_flush_o,   m_inf,  tag, "in_flush_o");
    check(err_o,        m_err,  tag, "err_o");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    tests_failed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int d0;
    wt_issue_i = 0; wb_ack_i = 0; flush_req_i = 0; flush_visit_i = 0;
    arst_n = 0;
    repeat (3) @(negedge clk);
    check(flush_done_o, 0, "R9", "done in reset");
    check(in_flush_o,   0, "R9", "in_flush in reset");
    check(err_o,        0, "R9", "err in reset");
    arst_n = 1;
    repeat (4) @(negedge clk);
    check(in_flush_o, 0, "R9", "in_flush after release");
    check(err_o,      0, "R9", "err after release");

    // R1 R3 R4 R5: three write-throughs in flight, flush, paired ack+visit
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R1");
    d0 = done_seen;
    step(0, 0, 1, 1, "R2");
    idle(2, "R2");
    step(0, 1, 0, 1, "R3");
    step(0, 1, 0, 1, "R3");
    tests_run++;
    if (done_seen != d0) begin
      tests_failed++;
      $display("FAIL R4 early done: actual=%0d expected=%0d", done_seen - d0, 0);
    end
    step(0, 1, 0, 1, "R4");
    tests_run++;
    if (done_seen != d0 + 1) begin
      tests_failed++;
      $display("FAIL R4 done count: actual=%0d expected=%0d", done_seen - d0, 1);
    end
    idle(2, "R5");

    // R4 R5: flush with nothing outstanding completes at once
    step(0, 0, 1, 1, "R5");
    idle(2, "R5");

    // R4: visits outside a flush are ignored
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R4");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 0, 1, "R4");
    step(0, 1, 0, 0, "R4");

    // R6: acknowledgement at zero
    step(0, 1, 0, 0, "R6");
    idle(1, "R6");

    // R8: issue and ack together at zero, and mid-range
    step(1, 1, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    step(1, 1, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");

    // R2 R3 R7: lone ack during flush consumes a completion, then underflows it
    step(1, 0, 0, 0, "R3");
    step(1, 0, 0, 0, "R3");
    step(0, 0, 1, 0, "R2");
    step(0, 0, 0, 1, "R3");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 1, "R5");
    idle(2, "R5");

    // R7 R8: saturate the outstanding count
    for (int i = 0; i < 257; i++) step(1, 0, 0, 0, "R7");
    step(1, 1, 0, 0, "R8");
    for (int i = 0; i < 255; i++) step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R6");
    idle(2, "R10");

    finish_run();
  end
endmodule